// File: doc/BRIEF.md
# Hit-Triggered Event Memory with Crossing Time Tag

This block sits behind a 64-channel front end. Each channel has two discriminator flags, one for a low threshold and one for a high threshold. While an acquisition window is open, the block collects the flags that rise during each bunch crossing. When a crossing ends and at least one flag has fired, the block writes one 168-bit event into an internal memory of 128 slots. The event holds the hit pattern of every channel, the value of a free-running 32-bit crossing counter and an 8-bit header.

When the memory holds 128 events, the block raises a full flag and closes the acquisition window by itself. Once the window is closed, a readout enable drains the stored events over one serial line, one bit per clock and oldest event first. A data-valid output is high for every bit that is sent. A crossing is marked by a one-cycle strobe in the block's clock domain. The crossing counter advances on every strobe, whether or not the window is open.

Top module: `hit_event_mem`

## Requirements
- R1: After reset, `sdata_vld` and `mem_full` are 0, the memory holds no events and the crossing counter is 0.
- R2: The crossing counter advances by one on every `bx_strobe`, inside or outside the window. An event stores the number of strobes seen since reset before the strobe that closes its crossing.
- R3: A crossing that ends while the window is open writes exactly one event if at least one flag fired during it, and no event if none fired.
- R4: Hit field bit 2c is the low-threshold flag of channel c and bit 2c+1 is the high-threshold flag. A flag seen in any cycle of a crossing, including the strobe cycle, is kept for that crossing. The kept flags are cleared when the crossing ends, so they never carry into the next crossing.
- R5: The event header is 1 in bit 7, with the 7-bit memory slot index (0 for the first event after reset) in bits 6..0.
- R6: Each event is sent as 168 consecutive bits with `sdata_vld` high: first the 8 header bits, then the 32 counter bits, then the 128 hit bits, each field MSB first.
- R7: Once 128 events are stored, `mem_full` goes high and stays high until reset, the window closes, and later crossings write nothing.
- R8: Readout runs only while the window is closed and `rd_en` is high. Events leave oldest first. The stream stops, with `sdata_vld` low, when every stored event has been sent.
- R9: Flags and strobes outside the window (before `acq_start`, or after `acq_stop`) store no event.
- R10: An event that has started to shift out always completes all 168 bits, even if `rd_en` falls. While `rd_en` stays high, the next event follows the last bit of the previous one without a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_strobe | input | 1 | One-cycle pulse that ends a bunch crossing |
| acq_start | input | 1 | Opens the acquisition window (ignored when full or while reading) |
| acq_stop | input | 1 | Closes the acquisition window |
| trig_lo | input | 64 | Low-threshold discriminator flags, one per channel |
| trig_hi | input | 64 | High-threshold discriminator flags, one per channel |
| rd_en | input | 1 | Allows serial readout of stored events |
| sdata | output | 1 | Serial event data |
| sdata_vld | output | 1 | High while `sdata` carries an event bit |
| mem_full | output | 1 | All 128 event slots are used |

## Verification
The hardest state to reach is the memory boundary. The full flag must appear after exactly the 128th event and must block the 129th and 130th crossings, and the read pointer must then stop at the write pointer after all 21,504 bits have gone out. The stimulus drives 130 crossings that each carry a hit. It samples the full flag after the 127th and the 128th event, then drains the memory and checks that the serial stream holds exactly 128 events with slot headers 0 through 127. A second hard case is a set of flags spread over several cycles of one crossing, followed by a crossing with no flags. It shows that the kept flags merge within a crossing and do not leak into the next one.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int HM_NCH    = 64;
  localparam int HM_BCID_W = 32;
  localparam int HM_HDR_W  = 8;
  localparam int HM_DEPTH  = 128;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_OPEN = 2'd1,
    WIN_DONE = 2'd2
  } win_state_t;
endpackage

// File: rtl/hm_bcid_ctr.sv
module hm_bcid_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bx_strobe,
  output logic [W-1:0] bcid
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         bcid <= '0;
    else if (bx_strobe) bcid <= bump(bcid);
  end
endmodule

// File: rtl/hm_hit_latch.sv
module hm_hit_latch #(
  parameter int NCH = 64,
  localparam int HIT_W = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_on,
  input  logic             bx_strobe,
  input  logic [NCH-1:0]   trig_lo,
  input  logic [NCH-1:0]   trig_hi,
  output logic [HIT_W-1:0] hits,
  output logic             hit_any
);
  logic [NCH-1:0] kept_lo, kept_hi;
  logic [NCH-1:0] seen_lo, seen_hi;

  assign seen_lo = kept_lo | trig_lo;
  assign seen_hi = kept_hi | trig_hi;

  for (genvar c = 0; c < NCH; c++) begin : g_pair
    assign hits[2*c]   = seen_lo[c];
    assign hits[2*c+1] = seen_hi[c];
  end

  assign hit_any = |hits;

  always_ff @(posedge clk) begin
    if (!rst_n || !acq_on || bx_strobe) begin
      kept_lo <= '0;
      kept_hi <= '0;
    end else begin
      kept_lo <= seen_lo;
      kept_hi <= seen_hi;
    end
  end
endmodule

// File: rtl/hm_event_store.sv
module hm_event_store #(
  parameter int EV_W  = 168,
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [EV_W-1:0]  wr_data,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic [EV_W-1:0]  rd_data,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             wr_fire,
  output logic             full
);
  logic [EV_W-1:0] mem [DEPTH];

  function automatic logic [PTR_W-1:0] slot_of(input logic [CNT_W-1:0] n);
    return n[PTR_W-1:0];
  endfunction

  assign full    = (wr_cnt == CNT_W'(DEPTH));
  assign wr_fire = wr_req && !full;
  assign rd_data = mem[slot_of(rd_cnt)];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[slot_of(wr_cnt)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_cnt <= '0;
    else if (wr_fire) wr_cnt <= wr_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/hm_serializer.sv
module hm_serializer #(
  parameter int EV_W  = 168,
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int BIT_W = $clog2(EV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [EV_W-1:0]  ev_data,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             start,
  output logic             busy,
  output logic             sdata,
  output logic             sdata_vld
);
  logic [EV_W-1:0]  shreg;
  logic [BIT_W-1:0] bitn;
  logic             last_bit;
  logic             pending;

  function automatic logic is_last(input logic [BIT_W-1:0] n);
    return n == BIT_W'(EV_W - 1);
  endfunction

  assign last_bit  = busy && is_last(bitn);
  assign pending   = (rd_cnt != wr_cnt);
  assign start     = allow && pending && (!busy || last_bit);
  assign sdata     = shreg[EV_W-1];
  assign sdata_vld = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bitn   <= '0;
      shreg  <= '0;
      rd_cnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      bitn   <= '0;
      shreg  <= ev_data;
      rd_cnt <= rd_cnt + CNT_W'(1);
    end else if (busy) begin
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        shreg <= shreg << 1;
        bitn  <= bitn + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hit_event_mem.sv
module hit_event_mem
  import hm_pkg::*;
#(
  parameter int NCH    = HM_NCH,
  parameter int BCID_W = HM_BCID_W,
  parameter int HDR_W  = HM_HDR_W,
  parameter int DEPTH  = HM_DEPTH,
  localparam int HIT_W = 2 * NCH,
  localparam int EV_W  = HDR_W + BCID_W + HIT_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bx_strobe,
  input  logic           acq_start,
  input  logic           acq_stop,
  input  logic [NCH-1:0] trig_lo,
  input  logic [NCH-1:0] trig_hi,
  input  logic           rd_en,
  output logic           sdata,
  output logic           sdata_vld,
  output logic           mem_full
);
  win_state_t       win;
  logic             acq_on;
  logic [BCID_W-1:0] bcid;
  logic [HIT_W-1:0] hits;
  logic             hit_any;
  logic             wr_req, wr_fire;
  logic [EV_W-1:0]  wr_data, rd_data;
  logic [CNT_W-1:0] wr_cnt, rd_cnt;
  logic             rd_start, rd_busy;

  function automatic logic [HDR_W-1:0] make_header(input logic [CNT_W-1:0] n);
    logic [HDR_W-1:0] h;
    h = HDR_W'(n[PTR_W-1:0]);
    h[HDR_W-1] = 1'b1;
    return h;
  endfunction

  assign acq_on  = (win == WIN_OPEN);
  assign wr_req  = acq_on && bx_strobe && hit_any;
  assign wr_data = {make_header(wr_cnt), bcid, hits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= WIN_IDLE;
    end else begin
      unique case (win)
        WIN_OPEN: if (acq_stop || mem_full) win <= WIN_DONE;
        default:  if (acq_start && !mem_full && !rd_busy && !rd_start) win <= WIN_OPEN;
      endcase
    end
  end

  hm_bcid_ctr #(.W(BCID_W)) u_bcid (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .bcid(bcid)
  );

  hm_hit_latch #(.NCH(NCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .acq_on(acq_on), .bx_strobe(bx_strobe),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .hits(hits), .hit_any(hit_any)
  );

  hm_event_store #(.EV_W(EV_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .rd_cnt(rd_cnt), .rd_data(rd_data), .wr_cnt(wr_cnt),
    .wr_fire(wr_fire), .full(mem_full)
  );

  hm_serializer #(.EV_W(EV_W), .DEPTH(DEPTH)) u_ser (
    .clk(clk), .rst_n(rst_n), .allow(rd_en && !acq_on), .wr_cnt(wr_cnt),
    .ev_data(rd_data), .rd_cnt(rd_cnt), .start(rd_start), .busy(rd_busy),
    .sdata(sdata), .sdata_vld(sdata_vld)
  );
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
  parameter int BCID_W = 32,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bx_strobe,
  input logic [BCID_W-1:0] bcid,
  input logic              acq_on,
  input logic              wr_fire,
  input logic [CNT_W-1:0]  wr_cnt,
  input logic [CNT_W-1:0]  rd_cnt,
  input logic              mem_full,
  input logic              sdata_vld
);
  p_bcid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bx_strobe |=> bcid == $past(bcid) + BCID_W'(1));

  p_bcid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_strobe |=> $stable(bcid));

  p_write_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> wr_cnt == $past(wr_cnt) + CNT_W'(1));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_cnt));

  p_full_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |=> !acq_on);

  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |=> mem_full);

  p_no_read_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_vld |-> !acq_on);

  always @(posedge clk) begin
    if (rst_n) begin
      p_rd_behind_r8: assert (rd_cnt <= wr_cnt);
      p_no_overflow_r7: assert (wr_cnt <= CNT_W'(DEPTH));
    end
  end
endmodule

bind hit_event_mem hm_checker #(.BCID_W(BCID_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .bcid(bcid),
  .acq_on(acq_on), .wr_fire(wr_fire), .wr_cnt(wr_cnt), .rd_cnt(rd_cnt),
  .mem_full(mem_full), .sdata_vld(sdata_vld)
);

// File: tb/sim_hit_event_mem.sv
module sim_hit_event_mem;
  localparam int NEV = 168;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bx_strobe = 1'b0, acq_start = 1'b0, acq_stop = 1'b0, rd_en = 1'b0;
  logic [63:0] trig_lo = '0, trig_hi = '0;
  logic sdata, sdata_vld, mem_full;

  int checks = 0, errors = 0;
  int bx_count = 0, exp_n = 0, rd_base = 0;
  logic [NEV-1:0] exp_w [128];

  localparam logic [63:0] T_LO [6] = '{64'h1, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                                       64'h0, 64'h0123_4567_89AB_CDEF};
  localparam logic [63:0] T_HI [6] = '{64'h0, 64'h0, 64'h8000_0000_0000_0000,
                                       64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hF0F0_0000_0000_0F0F};

  always #10 clk = ~clk;

  hit_event_mem u0 (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .acq_start(acq_start),
    .acq_stop(acq_stop), .trig_lo(trig_lo), .trig_hi(trig_hi), .rd_en(rd_en),
    .sdata(sdata), .sdata_vld(sdata_vld), .mem_full(mem_full)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add_exp(input logic [63:0] lo, input logic [63:0] hi);
    logic [NEV-1:0] w;
    logic [7:0] hdr;
    logic [31:0] tag;
    if (exp_n >= 128) return;
    hdr = 8'h80 + 8'(exp_n);
    tag = 32'(bx_count);
    w = '0;
    for (int k = 0; k < 8; k++)  w[NEV-8+k] = hdr[k];
    for (int k = 0; k < 32; k++) w[128+k] = tag[k];
    for (int c = 0; c < 64; c++) begin
      w[c*2]   = lo[c];
      w[c*2+1] = hi[c];
    end
    exp_w[exp_n] = w;
    exp_n++;
  endtask

  // flags in the cycle before the strobe, or in the strobe cycle itself
  task automatic crossing(input logic [63:0] lo, input logic [63:0] hi,
                          input bit in_strobe, input bit stored);
    if (!in_strobe) begin
      trig_lo = lo; trig_hi = hi; tick();
      trig_lo = '0; trig_hi = '0;
    end else begin
      trig_lo = lo; trig_hi = hi;
    end
    bx_strobe = 1'b1;
    if (stored && (lo | hi) != 0) add_exp(lo, hi);
    tick();
    bx_strobe = 1'b0; trig_lo = '0; trig_hi = '0;
    bx_count++;
  endtask

  task automatic pulse_start();
    acq_start = 1'b1; tick(); acq_start = 1'b0;
  endtask

  task automatic pulse_stop();
    acq_stop = 1'b1; tick(); acq_stop = 1'b0;
  endtask

  task automatic read_events(input int nev, input bit one_shot, input string req);
    bit q[$];
    int waitc = 0;
    rd_en = 1'b1; tick();
    if (one_shot) rd_en = 1'b0;
    while (!sdata_vld && waitc < 4) begin tick(); waitc++; end
    while (sdata_vld) begin q.push_back(sdata); tick(); end
    rd_en = 1'b0;
    check(q.size() == nev * NEV, req, "stream length", q.size(), nev * NEV);
    for (int e = 0; e < nev && (e + 1) * NEV <= q.size(); e++) begin
      int bad = -1;
      for (int b = 0; b < NEV; b++)
        if (q[e*NEV+b] != exp_w[rd_base+e][NEV-1-b] && bad < 0) bad = b;
      check(bad < 0, req, $sformatf("event %0d first bad bit %0d", rd_base + e, bad),
            bad, -1);
    end
    rd_base += nev;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1; tick();
    check(sdata_vld == 1'b0, "R1", "vld after reset", sdata_vld, 0);
    check(mem_full == 1'b0, "R1", "full after reset", mem_full, 0);

    // R9 and R2: flags outside the window store nothing, the counter still runs
    for (int i = 0; i < 3; i++) crossing(64'hFF << i, 64'h1, 0, 0);

    // R3/R4/R5/R6: walk the vector table inside the window
    pulse_start();
    for (int i = 0; i < 6; i++) begin
      crossing(T_LO[i], T_HI[i], 0, 1);
      check(mem_full == 1'b0, "R7", "full early", mem_full, 0);
    end

    // R8: readout is held off while the window is open
    rd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(sdata_vld == 1'b0, "R8", "vld inside window", sdata_vld, 0);
    end
    rd_en = 1'b0;
    pulse_stop();

    // R9: flags after the window closes are not stored
    crossing(64'hDEAD, 64'hBEEF, 0, 0);

    read_events(4, 0, "R6");          // 4 events, oldest first
    read_events(0, 0, "R8");          // nothing left after the last event

    // R4: flags spread over a crossing merge; kept flags clear at the crossing end
    pulse_start();
    trig_lo = 64'h20; tick();
    trig_lo = '0; trig_hi = 64'h1 << 60; tick();
    trig_hi = '0; trig_lo = 64'h1; bx_strobe = 1'b1;
    add_exp(64'h21, 64'h1 << 60);
    tick();
    bx_strobe = 1'b0; trig_lo = '0; bx_count++;
    crossing(64'h0, 64'h0, 1, 1);      // R4: empty crossing, no leftover
    crossing(64'h2, 64'h0, 1, 1);      // R4: flag in the strobe cycle
    pulse_stop();

    read_events(1, 1, "R10");         // single-cycle enable still yields one full event
    read_events(1, 0, "R4");
    read_events(0, 0, "R8");

    // R7: fill the memory from a fresh reset
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    bx_count = 0; exp_n = 0; rd_base = 0;
    check(mem_full == 1'b0 && sdata_vld == 1'b0, "R1", "state after second reset",
          {mem_full, sdata_vld}, 0);
    pulse_start();
    for (int i = 0; i < 130; i++) begin
      crossing(64'(i + 1), 64'(i) << 32, 0, 1);
      if (i == 126) check(mem_full == 1'b0, "R7", "full after 127 events", mem_full, 0);
      if (i == 127) check(mem_full == 1'b1, "R7", "full after 128 events", mem_full, 1);
    end
    check(exp_n == 128, "R7", "bench expected count", exp_n, 128);
    read_events(128, 0, "R7");        // R2: first event carries counter value 0
    check(mem_full == 1'b1, "R7", "full holds after readout", mem_full, 1);
    pulse_start();
    crossing(64'h5, 64'h5, 0, 0);
    read_events(0, 0, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule